// File: doc/BRIEF.md
# Class-Limited Micro-Op Dispatch Selector

Each cycle this block looks at a window of decoded micro-ops held in program order, slot 0 being the oldest. Every slot carries a valid bit and a 3-bit code that names the execution pipeline it is bound for. The block decides which of these ops move into the eight per-pipeline issue queues in this cycle.

Two kinds of limit apply together. The first is a cap on the total number of ops dispatched per cycle. The second is a separate cap for each group of pipelines. The window is scanned from oldest to youngest. An op whose group cap is already used up is skipped, and younger ops of other groups can still be granted past it.

The result is registered. It consists of a grant mask over the slots, the number of ops consumed and a write enable for each destination queue. Ops that are not granted stay upstream and are offered again later. A full destination queue takes its class out of the selection. A flush suppresses every grant for the cycle.

Top module: `dispatch_sel`

## Requirements
- R1: While rst_ni is low, and after it is released until the first window is captured, grant_o, grant_cnt_o and q_wr_en_o are all zero.
- R2: The outputs are registered. A window sampled at a rising clock edge is reflected on the outputs just after that edge and holds until the next edge.
- R3: At most 5 ops are granted per cycle. When more ops are eligible, only the 5 oldest eligible ops are granted.
- R4: Class codes are 0 branch, 1 integer A, 2 integer B, 3 multi-cycle, 4 float/vector A, 5 float/vector B, 6 load and 7 store. The per-cycle group caps are: branch 1, integer (codes 1 and 2 together) 2, multi-cycle 2, float/vector A 1, float/vector B 1, load/store (codes 6 and 7 together) 2.
- R5: Within a group, grants go oldest first. A granted op never has an older, eligible, ungranted op of the same group unless the total cap was reached first.
- R6: An op blocked by its group cap does not stop the scan. A younger eligible op of a group with room left is granted, provided the total cap allows it.
- R7: When q_full_i[c] is high, no slot with class code c is granted and q_wr_en_o[c] is low for that window.
- R8: When flush_i is high at an edge, the outputs after that edge show no grant, a count of zero and no queue write enable.
- R9: A slot whose valid bit is low is never granted.
- R10: grant_cnt_o equals the number of set bits in grant_o.
- R11: q_wr_en_o[c] is high exactly when at least one granted slot has class code c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Drop all grants for this window |
| slot_vld_i | input | 6 | Valid bit per slot, bit 0 oldest |
| slot_cls_i | input | 18 | 3-bit class code per slot, slot i at bits [3i+2:3i] |
| q_full_i | input | 8 | Destination queue full, indexed by class code |
| grant_o | output | 6 | Registered grant mask per slot |
| grant_cnt_o | output | 3 | Registered number of granted ops |
| q_wr_en_o | output | 8 | Registered write enable per destination queue |

## Verification
The assertions assume that the window inputs are stable around each rising edge and that class codes are always in the range 0 to 7. They also assume that flush_i and q_full_i are defined in every cycle after reset. The bench changes every input only on the falling edge. It draws class codes, valid bits, full bits and occasional flushes from a seeded $urandom stream and masks them into those ranges. It adds directed windows that saturate one group, overflow the total cap and mix blocked and bypassing ops.

// File: rtl/dispatch_sel_pkg.sv
package dispatch_sel_pkg;
  localparam int CLS_W   = 3;
  localparam int NUM_CLS = 1 << CLS_W;
  localparam int GRP_W   = 3;
  localparam int NUM_GRP = 1 << GRP_W;

  typedef enum logic [GRP_W-1:0] {
    GRP_BR  = 3'd0,
    GRP_INT = 3'd1,
    GRP_MC  = 3'd2,
    GRP_FA  = 3'd3,
    GRP_FB  = 3'd4,
    GRP_LS  = 3'd5
  } grp_e;

  // class code to cap group; integer pair and load/store pair share a cap
  function automatic grp_e grp_of(input logic [CLS_W-1:0] cls);
    unique case (cls)
      3'd0:        return GRP_BR;
      3'd1, 3'd2:  return GRP_INT;
      3'd3:        return GRP_MC;
      3'd4:        return GRP_FA;
      3'd5:        return GRP_FB;
      default:     return GRP_LS;
    endcase
  endfunction
endpackage

// File: rtl/dispatch_slot_decode.sv
module dispatch_slot_decode
  import dispatch_sel_pkg::*;
#(
  parameter int SLOTS = 6
) (
  input  logic [SLOTS-1:0]       vld_i,
  input  logic [SLOTS*CLS_W-1:0] cls_i,
  input  logic [NUM_CLS-1:0]     full_i,
  output logic [SLOTS-1:0]       elig_o,
  output logic [SLOTS*GRP_W-1:0] grp_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [CLS_W-1:0] cls;
    assign cls                      = cls_i[s*CLS_W +: CLS_W];
    assign elig_o[s]                = vld_i[s] & ~full_i[cls];
    assign grp_o[s*GRP_W +: GRP_W]  = grp_of(cls);
  end
endmodule

// File: rtl/dispatch_age_scan.sv
module dispatch_age_scan
  import dispatch_sel_pkg::*;
#(
  parameter int SLOTS     = 6,
  parameter int CNT_W     = 3,
  parameter int MAX_TOTAL = 5,
  parameter logic [NUM_GRP*CNT_W-1:0] CAPS = '0
) (
  input  logic [SLOTS-1:0]       elig_i,
  input  logic [SLOTS*GRP_W-1:0] grp_i,
  output logic [SLOTS-1:0]       gnt_o,
  output logic [CNT_W-1:0]       cnt_o
);
  logic [CNT_W-1:0] used [NUM_GRP];
  logic [CNT_W-1:0] total;
  logic [GRP_W-1:0] g;

  // oldest first; a capped op is skipped, scan continues
  always_comb begin
    for (int k = 0; k < NUM_GRP; k++) used[k] = '0;
    total = '0;
    gnt_o = '0;
    g     = '0;
    for (int s = 0; s < SLOTS; s++) begin
      g = grp_i[s*GRP_W +: GRP_W];
      if (elig_i[s] && (total < CNT_W'(MAX_TOTAL)) &&
          (used[g] < CAPS[g*CNT_W +: CNT_W])) begin
        gnt_o[s] = 1'b1;
        used[g]  = used[g] + 1'b1;
        total    = total + 1'b1;
      end
    end
    cnt_o = total;
  end
endmodule

// File: rtl/dispatch_sel.sv
module dispatch_sel
  import dispatch_sel_pkg::*;
#(
  parameter int SLOTS     = 6,
  parameter int MAX_TOTAL = 5,
  parameter int CAP_BR    = 1,
  parameter int CAP_INT   = 2,
  parameter int CAP_MC    = 2,
  parameter int CAP_FA    = 1,
  parameter int CAP_FB    = 1,
  parameter int CAP_LS    = 2,
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [SLOTS-1:0]       slot_vld_i,
  input  logic [SLOTS*CLS_W-1:0] slot_cls_i,
  input  logic [NUM_CLS-1:0]     q_full_i,
  output logic [SLOTS-1:0]       grant_o,
  output logic [CNT_W-1:0]       grant_cnt_o,
  output logic [NUM_CLS-1:0]     q_wr_en_o
);
  localparam logic [NUM_GRP*CNT_W-1:0] CAPS = {
    CNT_W'(0), CNT_W'(0), CNT_W'(CAP_LS), CNT_W'(CAP_FB),
    CNT_W'(CAP_FA), CNT_W'(CAP_MC), CNT_W'(CAP_INT), CNT_W'(CAP_BR)};

  logic [SLOTS-1:0]       elig;
  logic [SLOTS*GRP_W-1:0] grp;
  logic [SLOTS-1:0]       gnt_d;
  logic [CNT_W-1:0]       cnt_d;
  logic [NUM_CLS-1:0]     wr_d;

  dispatch_slot_decode #(.SLOTS(SLOTS)) u_dec (
    .vld_i  (slot_vld_i),
    .cls_i  (slot_cls_i),
    .full_i (q_full_i),
    .elig_o (elig),
    .grp_o  (grp)
  );

  dispatch_age_scan #(
    .SLOTS(SLOTS), .CNT_W(CNT_W), .MAX_TOTAL(MAX_TOTAL), .CAPS(CAPS)
  ) u_scan (
    .elig_i (elig),
    .grp_i  (grp),
    .gnt_o  (gnt_d),
    .cnt_o  (cnt_d)
  );

  always_comb begin
    wr_d = '0;
    for (int s = 0; s < SLOTS; s++)
      if (gnt_d[s]) wr_d[slot_cls_i[s*CLS_W +: CLS_W]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o     <= '0;
      grant_cnt_o <= '0;
      q_wr_en_o   <= '0;
    end else if (flush_i) begin
      grant_o     <= '0;
      grant_cnt_o <= '0;
      q_wr_en_o   <= '0;
    end else begin
      grant_o     <= gnt_d;
      grant_cnt_o <= cnt_d;
      q_wr_en_o   <= wr_d;
    end
  end

  // ---------------- assertions ----------------
  function automatic int grp_load(input logic [SLOTS-1:0] gm,
                                  input logic [SLOTS*CLS_W-1:0] cv,
                                  input int gi);
    int n = 0;
    for (int s = 0; s < SLOTS; s++)
      if (gm[s] && (int'(grp_of(cv[s*CLS_W +: CLS_W])) == gi)) n++;
    return n;
  endfunction

  AST_TOTAL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(grant_cnt_o) <= MAX_TOTAL); // R3

  for (genvar gi = 0; gi < NUM_GRP; gi++) begin : g_cap_chk
    AST_GROUP_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_load(gnt_d, slot_cls_i, gi) <= int'(CAPS[gi*CNT_W +: CNT_W])); // R4
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_full_chk
    AST_FULL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_full_i[c] |=> !q_wr_en_o[c]); // R7
  end

  AST_FLUSH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (grant_o == '0 && q_wr_en_o == '0)); // R8

  AST_NO_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((grant_o & ~$past(slot_vld_i)) == '0)); // R9

  AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == int'(grant_cnt_o)); // R10
endmodule

// File: tb/dispatch_sel_test.sv
module dispatch_sel_test;
  localparam int SLOTS = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic [5:0]  slot_vld_i = '0;
  logic [17:0] slot_cls_i = '0;
  logic [7:0]  q_full_i = '0;
  logic [5:0]  grant_o;
  logic [2:0]  grant_cnt_o;
  logic [7:0]  q_wr_en_o;

  int checks = 0;
  int errors = 0;

  dispatch_sel uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .slot_vld_i(slot_vld_i), .slot_cls_i(slot_cls_i), .q_full_i(q_full_i),
    .grant_o(grant_o), .grant_cnt_o(grant_cnt_o), .q_wr_en_o(q_wr_en_o)
  );

  always #5 clk_i = ~clk_i;

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int cap_of(input int c);
    case (c)
      0: return 1;
      1, 2: return 2;
      3: return 2;
      4: return 1;
      5: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int bucket(input int c);
    if (c == 2) return 1;
    if (c == 7) return 6;
    return c;
  endfunction

  function automatic logic [5:0] model(input logic [5:0] v, input logic [17:0] cl,
                                       input logic [7:0] f, input logic fl);
    int taken [8];
    int tot = 0;
    logic [5:0] g = '0;
    for (int k = 0; k < 8; k++) taken[k] = 0;
    if (fl) return '0;
    for (int s = 0; s < SLOTS; s++) begin
      int c = int'(cl[s*3 +: 3]);
      int b = bucket(c);
      if (v[s] && !f[c] && tot < 5 && taken[b] < cap_of(c)) begin
        g[s] = 1'b1; taken[b]++; tot++;
      end
    end
    return g;
  endfunction

  function automatic logic [7:0] wr_model(input logic [5:0] g, input logic [17:0] cl);
    logic [7:0] w = '0;
    for (int s = 0; s < SLOTS; s++) if (g[s]) w[cl[s*3 +: 3]] = 1'b1;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  logic [5:0] last_g = '0;

  task automatic apply(input string req, input logic [5:0] v, input logic [17:0] cl,
                       input logic [7:0] f, input logic fl);
    logic [5:0] eg;
    @(negedge clk_i);
    slot_vld_i = v; slot_cls_i = cl; q_full_i = f; flush_i = fl;
    #1 chk("R2 hold", 32'(grant_o), 32'(last_g));
    eg = model(v, cl, f, fl);
    @(negedge clk_i);
    chk({req, " grant"}, 32'(grant_o), 32'(eg));
    chk("R10 count", 32'(grant_cnt_o), 32'($countones(eg)));
    chk("R11 wr_en", 32'(q_wr_en_o), 32'(wr_model(eg, cl)));
    last_g = eg;
  endtask

  function automatic logic [17:0] pack(input int c0, c1, c2, c3, c4, c5);
    return {3'(c5), 3'(c4), 3'(c3), 3'(c2), 3'(c1), 3'(c0)};
  endfunction

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (2) @(negedge clk_i);
    chk("R1 grant in reset", 32'(grant_o), 0);
    chk("R1 count in reset", 32'(grant_cnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 wr_en after reset", 32'(q_wr_en_o), 0);

    // R4 R5: six branches, one granted (slot 0)
    apply("R4 branch cap", 6'h3f, pack(0,0,0,0,0,0), 8'h00, 1'b0);
    chk("R5 oldest branch", 32'(grant_o), 32'h01);
    // R4: integer group shares cap of 2 across codes 1 and 2
    apply("R4 int cap", 6'h3f, pack(2,1,2,1,1,2), 8'h00, 1'b0);
    chk("R4 int pair", 32'(grant_o), 32'h03);
    // R6: blocked int at slot 2 bypassed by load/store/branch
    apply("R6 bypass", 6'h3f, pack(1,2,1,6,7,0), 8'h00, 1'b0);
    chk("R6 bypass mask", 32'(grant_o), 32'h3b);
    // R3: six eligible ops in distinct groups, total cap stops at 5
    apply("R3 total", 6'h3f, pack(0,1,3,4,5,6), 8'h00, 1'b0);
    chk("R3 total mask", 32'(grant_o), 32'h1f);
    // R4: load/store combined cap
    apply("R4 ls cap", 6'h3f, pack(6,7,6,3,3,3), 8'h00, 1'b0);
    chk("R4 ls mask", 32'(grant_o), 32'h1b);
    // R7: integer B queue full
    apply("R7 full", 6'h07, pack(1,2,1,0,0,0), 8'h04, 1'b0);
    chk("R7 full mask", 32'(grant_o), 32'h05);
    chk("R7 wr_en", 32'(q_wr_en_o[2]), 0);
    // R8: flush
    apply("R8 flush", 6'h3f, pack(0,1,3,4,5,6), 8'h00, 1'b1);
    chk("R8 flush cnt", 32'(grant_cnt_o), 0);
    // R9: invalid slots
    apply("R9 invalid", 6'h2a, pack(0,0,4,4,5,5), 8'h00, 1'b0);
    chk("R9 mask", 32'(grant_o), 32'h2a);

    for (int it = 0; it < 400; it++) begin
      logic [17:0] cl = 18'($urandom);
      logic [5:0]  v  = 6'($urandom);
      logic [7:0]  f  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      logic        fl = (($urandom % 16) == 0);
      apply("R3 R4 R5 R6 R7 R9 random", v, cl, f, fl);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule